// File: doc/BRIEF.md
# Two-Phase Watchdog Timer with Pretimeout

This block is a watchdog with two stages. The first stage warns software and the second stage resets. It has a 32-bit word-addressed register interface with three registers. At offset 0x0 is the kick register. At offset 0x4 is the status register. At offset 0x8 is the configuration register.

A free-running clock drives a base divider of 2^BASE_DIV_LOG2 cycles, followed by a further 2^scale factor with scale from 0 to 3. The divided clock gives watchdog ticks. Once enabled, the first stage counts its tick budget and then raises a sticky warning flag and the interrupt line. The second stage then counts its own budget. When it runs out, it sets a second sticky flag and emits a one-cycle pulse on one of three reset outputs, chosen by a mode field. After the first stage has expired, clearing the enable bit no longer stops the sequence. Only a kick can hold the reset back.

Software enables the block and kicks it at regular intervals. The warning interrupt gives software one last chance to kick before the chosen reset kind fires.

Top module: `wdt_two_phase`

## Requirements
- R1: After reset the configuration register reads 0x00000001, the status register reads 0, and the interrupt and all three reset outputs are low.
- R2: Configuration fields sit at these positions: enable bit 31, scale bits 30:29, first-stage limit bits 26:22, second-stage limit bits 19:15, mode bits 1:0. All other bits read as 0, so writing 0xFFFFFFFF reads back as 0xE7CF8003.
- R3: A tick lasts 2^(BASE_DIV_LOG2+scale) clock cycles. When the enable bit is written to 1 from the stopped state, status bit 31 and the interrupt line become visible (L1+1)·tick + 1 cycles after the write edge, where L1 is the first-stage limit.
- R4: The second stage lasts (L2+1) ticks after the first stage ends. At its end, status bit 30 is set and exactly one reset output is high for exactly one cycle.
- R5: Mode 0 selects the chip reset output, mode 1 the CPU reset output and mode 2 the soft reset output. Mode 3 pulses no output but still sets status bit 30.
- R6: Clearing the enable bit during the first stage stops the block. No interrupt follows, and counting starts over at the next enable.
- R7: Clearing the enable bit during the second stage does not stop it. The reset pulse still comes at the original time.
- R8: Writing bit 31 = 1 to offset 0x0 in either stage restarts the first stage from zero, with its next tick a full tick later. It leaves the status bits unchanged. A write there with bit 31 = 0 has no effect.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. The interrupt line follows status bit 31.
- R10: After the reset pulse, the block stays halted and ignores kicks while enabled. A kick given while disabled returns it to the stopped state, from which a new enable starts a fresh sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pretimeout_irq | output | 1 | First-stage expiry interrupt (status bit 31) |
| chip_reset_pulse | output | 1 | One-cycle chip reset request |
| cpu_reset_pulse | output | 1 | One-cycle CPU reset request |
| soft_reset_pulse | output | 1 | One-cycle soft reset request |

## Verification
Reads are combinational, so a register's value is checked in the same cycle it is read. A write takes effect at the clock edge on which it is strobed. Counting from the negative clock edge after that write edge, the interrupt is due at (L1+1)·tick + 1 cycles after an enable, or at (L1+1)·tick cycles after a kick. The reset pulse is due (L2+1)·tick cycles after that, because the stage and prescaler registers each add their edge as expected. The bench advances one negative edge at a time with a running cycle count. It compares the count at which each output first rises against these formulas, and then checks the following cycle to confirm the pulse lasts a single cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int LIM_W = 5;

    localparam logic [3:0] OFS_KICK = 4'h0;
    localparam logic [3:0] OFS_STAT = 4'h4;
    localparam logic [3:0] OFS_CFG  = 4'h8;

    localparam int BIT_EN     = 31;
    localparam int BIT_KICK   = 31;
    localparam int BIT_FLAG1  = 31;
    localparam int BIT_FLAG2  = 30;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN1 = 2'd1,
        ST_RUN2 = 2'd2,
        ST_HALT = 2'd3
    } wdt_state_e;

    typedef enum logic [1:0] {
        MODE_CHIP = 2'd0,
        MODE_CPU  = 2'd1,
        MODE_SOFT = 2'd2,
        MODE_NONE = 2'd3
    } wdt_mode_e;

    typedef struct packed {
        logic             en;
        logic [1:0]       scale;
        logic [LIM_W-1:0] lim1;
        logic [LIM_W-1:0] lim2;
        wdt_mode_e        mode;
    } wdt_cfg_t;

    function automatic wdt_cfg_t cfg_from_word(input logic [31:0] w);
        wdt_cfg_t c;
        c.en    = w[31];
        c.scale = w[30:29];
        c.lim1  = w[26:22];
        c.lim2  = w[19:15];
        c.mode  = wdt_mode_e'(w[1:0]);
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(input wdt_cfg_t c);
        logic [31:0] w;
        w        = '0;
        w[31]    = c.en;
        w[30:29] = c.scale;
        w[26:22] = c.lim1;
        w[19:15] = c.lim2;
        w[1:0]   = c.mode;
        return w;
    endfunction

    // bit 0 chip, bit 1 cpu, bit 2 soft
    function automatic logic [2:0] mode_lines(input wdt_mode_e m);
        case (m)
            MODE_CHIP: return 3'b001;
            MODE_CPU:  return 3'b010;
            MODE_SOFT: return 3'b100;
            default:   return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              set_flag1,
    input  logic              set_flag2,
    output logic [31:0]       bus_rdata,
    output wdt_cfg_t          cfg,
    output logic              kick,
    output logic              flag1,
    output logic              flag2
);

    logic wr_cfg, wr_stat;

    assign wr_cfg  = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_CFG));
    assign wr_stat = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_STAT));
    assign kick    = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_KICK))
                     && bus_wdata[BIT_KICK];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= cfg_from_word(32'h0000_0001);
        end else if (wr_cfg) begin
            cfg <= cfg_from_word(bus_wdata);
        end
    end

    // a set from the timer wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            flag1 <= 1'b0;
            flag2 <= 1'b0;
        end else begin
            if (set_flag1)                          flag1 <= 1'b1;
            else if (wr_stat && bus_wdata[BIT_FLAG1]) flag1 <= 1'b0;
            if (set_flag2)                          flag2 <= 1'b1;
            else if (wr_stat && bus_wdata[BIT_FLAG2]) flag2 <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CFG)) begin
            bus_rdata = cfg_to_word(cfg);
        end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
            bus_rdata[BIT_FLAG1] = flag1;
            bus_rdata[BIT_FLAG2] = flag2;
        end
    end

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int BASE_DIV_LOG2 = 25
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       clear,
    input  logic [1:0] scale,
    output logic       tick
);

    localparam int CNT_W = BASE_DIV_LOG2 + 3;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // at the largest scale the shift wraps to zero and the subtraction gives all ones
    assign last = (CNT_W'(1) << (BASE_DIV_LOG2 + int'(scale))) - CNT_W'(1);
    assign tick = run && !clear && (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdt_phase_fsm.sv
module wdt_phase_fsm
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wdt_cfg_t   cfg,
    input  logic       kick,
    input  logic       tick,
    output wdt_state_e st,
    output logic       presc_run,
    output logic       presc_clear,
    output logic       hit1,
    output logic       hit2,
    output logic [2:0] rst_lines
);

    wdt_state_e       st_nxt;
    logic [LIM_W-1:0] tcnt, tcnt_nxt;

    always_comb begin
        st_nxt   = st;
        tcnt_nxt = tcnt;
        hit1     = 1'b0;
        hit2     = 1'b0;
        unique case (st)
            ST_IDLE: begin
                tcnt_nxt = '0;
                if (cfg.en) st_nxt = ST_RUN1;
            end
            ST_RUN1: begin
                if (kick) begin
                    tcnt_nxt = '0;
                end else if (!cfg.en) begin
                    st_nxt   = ST_IDLE;
                    tcnt_nxt = '0;
                end else if (tick) begin
                    if (tcnt == cfg.lim1) begin
                        hit1     = 1'b1;
                        st_nxt   = ST_RUN2;
                        tcnt_nxt = '0;
                    end else begin
                        tcnt_nxt = tcnt + 1'b1;
                    end
                end
            end
            ST_RUN2: begin
                if (kick) begin
                    st_nxt   = ST_RUN1;
                    tcnt_nxt = '0;
                end else if (tick) begin
                    if (tcnt == cfg.lim2) begin
                        hit2     = 1'b1;
                        st_nxt   = ST_HALT;
                        tcnt_nxt = '0;
                    end else begin
                        tcnt_nxt = tcnt + 1'b1;
                    end
                end
            end
            ST_HALT: begin
                if (kick && !cfg.en) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    assign presc_run   = (st == ST_RUN1) || (st == ST_RUN2);
    assign presc_clear = kick || !presc_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            tcnt      <= '0;
            rst_lines <= '0;
        end else begin
            st        <= st_nxt;
            tcnt      <= tcnt_nxt;
            rst_lines <= hit2 ? mode_lines(cfg.mode) : 3'b000;
        end
    end

endmodule

// File: rtl/wdt_two_phase.sv
module wdt_two_phase
    import wdt_pkg::*;
#(
    parameter int BASE_DIV_LOG2 = 25,
    parameter int ADDR_W        = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pretimeout_irq,
    output logic              chip_reset_pulse,
    output logic              cpu_reset_pulse,
    output logic              soft_reset_pulse
);

    wdt_cfg_t   cfg;
    wdt_state_e st;
    logic       kick, tick, presc_run, presc_clear;
    logic       hit1, hit2, stat_ph1, stat_ph2;
    logic [2:0] rst_lines;

    wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .set_flag1 (hit1),
        .set_flag2 (hit2),
        .bus_rdata (bus_rdata),
        .cfg       (cfg),
        .kick      (kick),
        .flag1     (stat_ph1),
        .flag2     (stat_ph2)
    );

    wdt_prescaler #(.BASE_DIV_LOG2(BASE_DIV_LOG2)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .run   (presc_run),
        .clear (presc_clear),
        .scale (cfg.scale),
        .tick  (tick)
    );

    wdt_phase_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .kick        (kick),
        .tick        (tick),
        .st          (st),
        .presc_run   (presc_run),
        .presc_clear (presc_clear),
        .hit1        (hit1),
        .hit2        (hit2),
        .rst_lines   (rst_lines)
    );

    assign pretimeout_irq   = stat_ph1;
    assign chip_reset_pulse = rst_lines[0];
    assign cpu_reset_pulse  = rst_lines[1];
    assign soft_reset_pulse = rst_lines[2];

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              stat_ph1,
    input logic              stat_ph2,
    input logic              kick,
    input wdt_state_e        st,
    input wdt_cfg_t          cfg,
    input logic              chip_reset_pulse,
    input logic              cpu_reset_pulse,
    input logic              soft_reset_pulse
);

    logic [2:0] pulses;
    logic       clr1;

    assign pulses = {soft_reset_pulse, cpu_reset_pulse, chip_reset_pulse};
    assign clr1   = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_STAT))
                    && bus_wdata[BIT_FLAG1];

    // R4
    one_line_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulses));

    // R4
    single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (|pulses) |=> !(|pulses));

    // R4
    pulse_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (|pulses) |-> stat_ph2);

    // R5
    mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (|pulses) |-> ($past(cfg.mode) != MODE_NONE));

    // R6
    stop_run1_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN1 && !cfg.en && !kick) |=> (st == ST_IDLE));

    // R7
    locked_run2_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN2 && !kick) |=> (st == ST_RUN2 || st == ST_HALT));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_ph1 && !clr1) |=> stat_ph1);

endmodule

bind wdt_two_phase wdt_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .bus_sel          (bus_sel),
    .bus_we           (bus_we),
    .bus_addr         (bus_addr),
    .bus_wdata        (bus_wdata),
    .stat_ph1         (stat_ph1),
    .stat_ph2         (stat_ph2),
    .kick             (kick),
    .st               (st),
    .cfg              (cfg),
    .chip_reset_pulse (chip_reset_pulse),
    .cpu_reset_pulse  (cpu_reset_pulse),
    .soft_reset_pulse (soft_reset_pulse)
);

// File: tb/wdt_two_phase_tb.sv
module wdt_two_phase_tb;

    localparam int BASE = 2;
    localparam int AW   = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_sel, bus_we;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic          irq, p_chip, p_cpu, p_soft;

    always #5 clk = ~clk;

    wdt_two_phase #(.BASE_DIV_LOG2(BASE), .ADDR_W(AW)) u_dut (
        .clk              (clk),
        .rst              (rst),
        .bus_sel          (bus_sel),
        .bus_we           (bus_we),
        .bus_addr         (bus_addr),
        .bus_wdata        (bus_wdata),
        .bus_rdata        (bus_rdata),
        .pretimeout_irq   (irq),
        .chip_reset_pulse (p_chip),
        .cpu_reset_pulse  (p_cpu),
        .soft_reset_pulse (p_soft)
    );

    int  checks = 0;
    int  errors = 0;
    int  n      = 0;
    bit  done   = 1'b0;

    function automatic logic [2:0] pulses();
        return {p_soft, p_cpu, p_chip};
    endfunction

    function automatic int tick_len(input int sc);
        return 1 << (BASE + sc);
    endfunction

    function automatic logic [31:0] cfg_word(input bit en, input int sc,
                                             input int l1, input int l2, input int md);
        logic [31:0] w;
        w        = '0;
        w[31]    = en;
        w[30:29] = 2'(sc);
        w[26:22] = 5'(l1);
        w[19:15] = 5'(l2);
        w[1:0]   = 2'(md);
        return w;
    endfunction

    function automatic logic [2:0] exp_lines(input int md);
        case (md)
            0: return 3'b001;
            1: return 3'b010;
            2: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        n++;
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        n += 2;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
        #1 d = bus_rdata;
        bus_sel = 1'b0;
        n++;
    endtask

    task automatic wait_irq(input int lim);
        while (!irq && n < lim) step();
    endtask

    task automatic wait_pulse(input int lim, output logic [2:0] seen);
        while (pulses() == 3'b000 && n < lim) step();
        seen = pulses();
    endtask

    task automatic recover();
        bus_wr(4'h8, 32'h0);
        bus_wr(4'h0, 32'h8000_0000);
        bus_wr(4'h4, 32'hC000_0000);
    endtask

    // full sequence from an enable write; checks both stage times and the pulse
    task automatic run_full(input int sc, input int l1, input int l2, input int md);
        int t, e1, e2;
        logic [2:0]  seen;
        logic [31:0] r;
        t  = tick_len(sc);
        e1 = 1 + (l1 + 1) * t;
        e2 = 1 + (l1 + l2 + 2) * t;
        bus_wr(4'h8, cfg_word(1'b1, sc, l1, l2, md));
        n = 0;
        wait_irq(e1 + 4);
        chk("R3 first stage cycles", n, e1);
        if (md == 3) begin
            wait_pulse(e2 + t, seen);
            chk("R5 mode 3 no pulse", seen, 3'b000);
            bus_rd(4'h4, r);
            chk("R5 mode 3 flag set", r, 32'hC000_0000);
        end else begin
            wait_pulse(e2 + 4, seen);
            chk("R4 second stage cycles", n, e2);
            chk("R5 selected line", seen, exp_lines(md));
            step();
            chk("R4 pulse one cycle", pulses(), 3'b000);
            bus_rd(4'h4, r);
            chk("R4 both flags", r, 32'hC000_0000);
        end
        recover();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [2:0]  seen;
        int          t, e1, e2;
        void'($urandom(32'd4242));
        rst = 1'b1; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_rd(4'h8, r); chk("R1 config reset", r, 32'h0000_0001);
        bus_rd(4'h4, r); chk("R1 status reset", r, 32'h0);
        chk("R1 outputs low", {irq, pulses()}, 4'b0);

        // R2 field layout, then stop before anything expires
        bus_wr(4'h8, 32'hFFFF_FFFF);
        bus_rd(4'h8, r); chk("R2 field mask", r, 32'hE7CF_8003);
        bus_wr(4'h8, 32'h0000_0001);
        bus_rd(4'h8, r); chk("R2 write back", r, 32'h0000_0001);
        bus_wr(4'h0, 32'h8000_0000);

        // directed: zero limits and every mode
        run_full(0, 0, 0, 0);
        run_full(0, 0, 0, 1);
        run_full(1, 2, 1, 2);
        run_full(0, 1, 1, 3);

        // random configurations
        for (int i = 0; i < 12; i++) begin
            run_full($urandom_range(3, 0), $urandom_range(7, 0),
                     $urandom_range(7, 0), $urandom_range(3, 0));
        end

        // R6 stop in first stage, then restart counts from zero
        t = tick_len(0);
        bus_wr(4'h8, cfg_word(1'b1, 0, 3, 1, 0));
        n = 0;
        repeat (10) step();
        bus_wr(4'h8, cfg_word(1'b0, 0, 3, 1, 0));
        repeat (8 * t) step();
        chk("R6 no irq after stop", irq, 1'b0);
        bus_wr(4'h8, cfg_word(1'b1, 0, 3, 1, 0));
        n = 0;
        wait_irq(4 * t + 5);
        chk("R6 restart from zero", n, 4 * t + 1);
        recover();

        // R7 disable during second stage
        e2 = 1 + (2 + 3 + 2) * t;
        bus_wr(4'h8, cfg_word(1'b1, 0, 2, 3, 1));
        n = 0;
        wait_irq(e2);
        bus_wr(4'h8, cfg_word(1'b0, 0, 2, 3, 1));
        wait_pulse(e2 + 4, seen);
        chk("R7 pulse time unchanged", n, e2);
        chk("R7 pulse line", seen, 3'b010);
        recover();

        // R8 kick in first stage, and a no-op write to the kick register
        e1 = 1 + 6 * t;
        bus_wr(4'h8, cfg_word(1'b1, 0, 5, 0, 0));
        n = 0;
        repeat (6) step();
        bus_wr(4'h0, 32'h7FFF_FFFF);
        wait_irq(e1 + 4);
        chk("R8 bit31 zero no kick", n, e1);
        recover();
        bus_wr(4'h8, cfg_word(1'b1, 0, 5, 0, 0));
        repeat (10) step();
        bus_wr(4'h0, 32'h8000_0000);
        n = 0;
        wait_irq(6 * t + 4);
        chk("R8 kick restarts stage one", n, 6 * t);
        // R8 kick in second stage keeps flag and restarts from stage one
        bus_wr(4'h0, 32'h8000_0000);
        n = 0;
        bus_rd(4'h4, r);
        chk("R8 flag kept after kick", r, 32'h8000_0000);
        wait_pulse(7 * t + 4, seen);
        chk("R8 pulse after kick", n, 7 * t);
        chk("R8 pulse line", seen, 3'b001);

        // R9 write-one-to-clear
        bus_wr(4'h4, 32'h0);
        bus_rd(4'h4, r); chk("R9 zero write keeps", r, 32'hC000_0000);
        bus_wr(4'h4, 32'h4000_0000);
        bus_rd(4'h4, r); chk("R9 clear bit30 only", r, 32'h8000_0000);
        chk("R9 irq still high", irq, 1'b1);
        bus_wr(4'h4, 32'h8000_0000);
        bus_rd(4'h4, r); chk("R9 clear bit31", r, 32'h0);
        chk("R9 irq low", irq, 1'b0);

        // R10 halted: kick while enabled ignored
        bus_wr(4'h0, 32'h8000_0000);
        seen = 3'b000;
        for (int k = 0; k < 40 * t; k++) begin
            step();
            seen |= pulses();
        end
        chk("R10 no pulse while halted", seen, 3'b000);
        chk("R10 no irq while halted", irq, 1'b0);
        bus_wr(4'h8, cfg_word(1'b0, 0, 1, 0, 2));
        bus_wr(4'h0, 32'h8000_0000);
        bus_wr(4'h8, cfg_word(1'b1, 0, 1, 0, 2));
        n = 0;
        wait_irq(2 * t + 5);
        chk("R10 fresh sequence irq", n, 2 * t + 1);
        wait_pulse(3 * t + 5, seen);
        chk("R10 fresh sequence pulse", seen, 3'b100);
        recover();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule